// File: doc/BRIEF.md
# Character Display Instruction Decoder

This block sits between a host bus and the character memory of a two-row, sixteen-column character display. The host drives a register-select line, a read/write line, an enable strobe and an eight-bit data byte. The block captures each bus cycle when the enable strobe falls. That edge is found by comparing the strobe against its value on the previous clock.

A cycle with register-select low is an instruction write or a status read. A cycle with register-select high writes or reads one character cell in the 32-byte display memory. Instructions are classified by the position of their most significant set bit. The block holds the cursor-advance direction, the display on/cursor/blink flags, a display scroll offset and a seven-bit address counter. It makes the whole character memory and all flags visible on output ports so that a renderer can consume them.

Every accepted write makes the block busy for a programmable number of clocks, and any write that lands while busy is dropped. Reads are always served.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: Nothing in the display memory, flags, scroll offset or `dout` changes except in the clock cycle where `en` is seen low after being high on the previous clock. `rs`, `rw` and `din` are taken in that cycle.
- R2: A status read (`rs`=0, `rw`=1) loads `dout` on the clock edge that sees the strobe fall. Bit 7 of `dout` holds the busy flag as it was before that edge, and bits 6:0 hold the address counter.
- R3: Instruction 0x01 fills all 32 cells with 0x20 and zeroes the address counter and the scroll offset. It starts the long busy count.
- R4: Instructions 0x02 and 0x03 zero the address counter and the scroll offset, leave the memory untouched and start the long busy count.
- R5: Instructions 0x04 to 0x07 store bit 1 as the advance direction (1 = up) and bit 0 as scroll-on-write.
- R6: Instructions 0x08 to 0x0F store bit 2 in `disp_on`, bit 1 in `cursor_on` and bit 0 in `blink_on`.
- R7: For instructions 0x10 to 0x1F, bit 2 picks the direction (1 = +1, 0 = -1), modulo 32. When bit 3 is 1 the step is applied to the scroll offset; when bit 3 is 0 it is applied to the address counter, and the counter's bits 6:5 are cleared.
- R8: Instructions 0x00 and 0x20 to 0x7F change no display memory, flag, offset or counter. They still start the short busy count.
- R9: An instruction with bit 7 set loads the address counter with bits 6:0.
- R10: A data write (`rs`=1, `rw`=0) stores `din` in the cell at counter bits 4:0. The counter then becomes that index +1 or -1, modulo 32, with bits 6:5 cleared. If scroll-on-write is set, the scroll offset moves by the same step.
- R11: A data read (`rs`=1, `rw`=1) loads `dout` with the cell at counter bits 4:0 and advances the counter as in R10. It never moves the scroll offset.
- R12: An accepted write raises `busy` for BUSY_SHORT clocks, or for BUSY_LONG clocks after instructions 0x01 to 0x03. A write that arrives while `busy` is high is dropped, and reads are served regardless of `busy`.
- R13: After reset, every cell holds 0x20 and the counter, offset and `dout` are 0. Display, cursor and blink are off, the direction is up, scroll-on-write is off, and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rs | input | 1 | Register select: 0 = instruction/status, 1 = character data |
| rw | input | 1 | 1 = read, 0 = write |
| en | input | 1 | Bus strobe; the cycle is taken when it falls |
| din | input | 8 | Byte written by the host |
| dout | output | 8 | Byte returned by the last read cycle |
| busy | output | 1 | High while the block is still processing a write |
| disp_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor visible |
| blink_on | output | 1 | Cursor blinking |
| entry_inc | output | 1 | Advance direction after a data access (1 = up) |
| entry_shift | output | 1 | Scroll the display on each data write |
| shift_ofs | output | 5 | Display scroll offset |
| ram_flat | output | 256 | All 32 character cells, cell i at bits 8i+7:8i |

## Verification
On every clock the checker confirms the following:
- State is frozen without a strobe fall.
- A status read returns the prior busy bit.
- The display-control bits land in the flags.
- Clearing yields an all-space memory.
- Busy rises on every accepted write.
- Writes made while busy leave memory and flags alone.

Only the bench's scenarios can show the rest:
- The exact busy durations.
- Address-counter wrap in both directions.
- The effect of scroll-on-write.
- Counter loads with bits 6:5 set.
- The no-effect instruction ranges.
- The agreement of random mixes of reads, writes and instructions with a reference model.

// File: rtl/lcd_pkg.sv
// Package for the display instruction decoder.
// Defines the instruction classes and the classifier that picks a class
// from the most significant set bit of an instruction byte.
package lcd_pkg;

    typedef enum logic [3:0] {
        K_NOP, K_CLEAR, K_HOME, K_ENTRY, K_DISPCTL,
        K_SHIFT, K_FUNC, K_GLYPH_ADDR, K_CELL_ADDR
    } cmd_kind_e;

    // Class of an instruction byte: the highest set bit wins.
    function automatic cmd_kind_e classify(input logic [7:0] b);
        cmd_kind_e k;
        k = K_NOP;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) begin
                case (i)
                    0:       k = K_CLEAR;
                    1:       k = K_HOME;
                    2:       k = K_ENTRY;
                    3:       k = K_DISPCTL;
                    4:       k = K_SHIFT;
                    5:       k = K_FUNC;
                    6:       k = K_GLYPH_ADDR;
                    default: k = K_CELL_ADDR;
                endcase
            end
        end
        return k;
    endfunction

endpackage

// File: rtl/lcd_strobe.sv
// Strobe edge finder.
// Flags the clock cycle in which the enable strobe is low after being high
// on the previous clock. It assumes the strobe is already synchronous to clk.
module lcd_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic fall
);
    logic en_q;

    // Remember the strobe level from the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    assign fall = en_q & ~en;
endmodule

// File: rtl/lcd_busy_timer.sv
// Busy countdown.
// A load starts a count of SHORT or LONG clocks; busy is high while the
// count is non-zero. It assumes LONG >= SHORT >= 1.
module lcd_busy_timer #(
    parameter int SHORT = 4,
    parameter int LONG  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    output logic busy
);
    localparam int CW = $clog2(LONG + 1);

    logic [CW-1:0] cnt;

    // Load a new count on an accepted write, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= long_sel ? CW'(LONG) : CW'(SHORT);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/lcd_ram.sv
// Character memory.
// NCHAR byte cells with a one-cycle fill to the space code, one write port
// and one combinational read port. The fill takes priority over a write.
module lcd_ram #(
    parameter int NCHAR = 32,
    parameter int AW    = $clog2(NCHAR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [7:0]         wdata,
    input  logic [AW-1:0]      raddr,
    output logic [7:0]         rdata,
    output logic [8*NCHAR-1:0] flat
);
    localparam logic [7:0] SPACE = 8'h20;

    logic [7:0] mem [NCHAR];

    // Reset or clear fills every cell with spaces; otherwise write one cell.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < NCHAR; i++) mem[i] <= SPACE;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // Expose every cell on the flat output.
    for (genvar g = 0; g < NCHAR; g++) begin : g_flat
        assign flat[8*g +: 8] = mem[g];
    end
endmodule

// File: rtl/lcd_cmd_decoder.sv
// Display instruction decoder, top level.
// Takes a host bus cycle when the enable strobe falls. It decodes instruction
// writes, writes and reads character cells, and answers status reads. It holds
// the display flags, scroll offset and address counter. Assumes rs/rw/din are
// stable in the clock cycle where the strobe fall is seen, and NCHAR is a
// power of two not larger than 128.
module lcd_cmd_decoder
    import lcd_pkg::*;
#(
    parameter int NCHAR      = 32,
    parameter int BUSY_SHORT = 4,
    parameter int BUSY_LONG  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rs,
    input  logic               rw,
    input  logic               en,
    input  logic [7:0]         din,
    output logic [7:0]         dout,
    output logic               busy,
    output logic               disp_on,
    output logic               cursor_on,
    output logic               blink_on,
    output logic               entry_inc,
    output logic               entry_shift,
    output logic [4:0]         shift_ofs,
    output logic [8*NCHAR-1:0] ram_flat
);
    localparam int AW  = $clog2(NCHAR);
    localparam int ACW = 7;

    logic            fall;
    logic            wr_ok, wr_cmd, wr_data, rd_cyc;
    logic            long_sel;
    cmd_kind_e       kind;
    logic [ACW-1:0]  ac;
    logic [7:0]      rdata;
    logic [AW-1:0]   ac_next;

    // One step of an AW-bit index, up or down, wrapping.
    function automatic logic [AW-1:0] step(input logic [AW-1:0] v, input logic up);
        return up ? v + 1'b1 : v - 1'b1;
    endfunction

    // One step of the scroll offset, up or down, wrapping.
    function automatic logic [4:0] ostep(input logic [4:0] v, input logic up);
        return up ? v + 1'b1 : v - 1'b1;
    endfunction

    lcd_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .fall  (fall)
    );

    assign kind     = classify(din);
    assign wr_ok    = fall & ~rw & ~busy;
    assign wr_cmd   = wr_ok & ~rs;
    assign wr_data  = wr_ok & rs;
    assign rd_cyc   = fall & rw;
    assign long_sel = wr_cmd & (kind == K_CLEAR || kind == K_HOME);
    assign ac_next  = step(ac[AW-1:0], entry_inc);

    lcd_busy_timer #(
        .SHORT (BUSY_SHORT),
        .LONG  (BUSY_LONG)
    ) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_ok),
        .long_sel (long_sel),
        .busy     (busy)
    );

    lcd_ram #(
        .NCHAR (NCHAR),
        .AW    (AW)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_cmd && kind == K_CLEAR),
        .we    (wr_data),
        .waddr (ac[AW-1:0]),
        .wdata (din),
        .raddr (ac[AW-1:0]),
        .rdata (rdata),
        .flat  (ram_flat)
    );

    // Control state: read returns, counter, offset and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout        <= 8'h00;
            ac          <= '0;
            shift_ofs   <= '0;
            disp_on     <= 1'b0;
            cursor_on   <= 1'b0;
            blink_on    <= 1'b0;
            entry_inc   <= 1'b1;
            entry_shift <= 1'b0;
        end else begin
            if (rd_cyc) begin
                if (!rs) begin
                    dout <= {busy, ac};
                end else begin
                    dout <= rdata;
                    ac   <= ACW'(ac_next);
                end
            end
            if (wr_data) begin
                ac <= ACW'(ac_next);
                if (entry_shift) shift_ofs <= ostep(shift_ofs, entry_inc);
            end
            if (wr_cmd) begin
                case (kind)
                    K_CLEAR, K_HOME: begin
                        ac        <= '0;
                        shift_ofs <= '0;
                    end
                    K_ENTRY: begin
                        entry_inc   <= din[1];
                        entry_shift <= din[0];
                    end
                    K_DISPCTL: begin
                        disp_on   <= din[2];
                        cursor_on <= din[1];
                        blink_on  <= din[0];
                    end
                    K_SHIFT: begin
                        if (din[3]) shift_ofs <= ostep(shift_ofs, din[2]);
                        else        ac        <= ACW'(step(ac[AW-1:0], din[2]));
                    end
                    K_CELL_ADDR: ac <= din[6:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/lcd_cmd_decoder_chk.sv
// Property checker for the display instruction decoder.
// Observes the top-level ports only. It keeps its own copy of the previous
// strobe level to find bus cycles.
module lcd_cmd_decoder_chk #(
    parameter int NCHAR = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rs,
    input logic               rw,
    input logic               en,
    input logic [7:0]         din,
    input logic [7:0]         dout,
    input logic               busy,
    input logic               disp_on,
    input logic               cursor_on,
    input logic               blink_on,
    input logic               entry_inc,
    input logic               entry_shift,
    input logic [4:0]         shift_ofs,
    input logic [8*NCHAR-1:0] ram_flat
);
    logic en_d;
    logic fall;
    logic [4:0] cfg;

    // Previous strobe level, seen independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) en_d <= 1'b0;
        else        en_d <= en;
    end

    assign fall = en_d & ~en;
    assign cfg  = {disp_on, cursor_on, blink_on, entry_inc, entry_shift};

    AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> ($stable(ram_flat) && $stable(cfg) && $stable(shift_ofs) && $stable(dout))); // R1

    AST_STATUS_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !rs && rw) |=> (dout[7] == $past(busy))); // R2

    AST_CLEAR_SPACES: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !rs && !rw && !busy && din == 8'h01) |=> (ram_flat == {NCHAR{8'h20}})); // R3

    AST_DISPCTL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !rs && !rw && !busy && din[7:3] == 5'b00001)
        |=> ({disp_on, cursor_on, blink_on} == $past(din[2:0]))); // R6

    AST_BUSY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !rw && !busy) |=> busy); // R12

    AST_BUSY_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !rw && busy) |=> ($stable(ram_flat) && $stable(cfg) && $stable(shift_ofs))); // R12
endmodule

bind lcd_cmd_decoder lcd_cmd_decoder_chk #(.NCHAR(NCHAR)) u_chk (.*);

// File: tb/lcd_cmd_decoder_tb.sv
`timescale 1ns/1ps
module lcd_cmd_decoder_tb;
    localparam int NCHAR = 32;
    localparam int SHORT = 4;
    localparam int LONG  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rs = 1'b0, rw = 1'b0, en = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic busy, disp_on, cursor_on, blink_on, entry_inc, entry_shift;
    logic [4:0] shift_ofs;
    logic [8*NCHAR-1:0] ram_flat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [7:0] mram [NCHAR];
    logic [6:0] mac;
    logic [4:0] mofs;
    logic mdisp, mcur, mblink, minc, msh;

    always #4 clk = ~clk;

    lcd_cmd_decoder #(.NCHAR(NCHAR), .BUSY_SHORT(SHORT), .BUSY_LONG(LONG)) u_dut (
        .clk(clk), .rst_n(rst_n), .rs(rs), .rw(rw), .en(en), .din(din),
        .dout(dout), .busy(busy), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .entry_inc(entry_inc), .entry_shift(entry_shift),
        .shift_ofs(shift_ofs), .ram_flat(ram_flat)
    );

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [8*NCHAR-1:0] model_flat();
        logic [8*NCHAR-1:0] f;
        for (int i = 0; i < NCHAR; i++) f[8*i +: 8] = mram[i];
        return f;
    endfunction

    function automatic logic [4:0] wrap5(input logic [4:0] v, input logic up);
        return up ? v + 5'd1 : v - 5'd1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCHAR; i++) mram[i] = 8'h20;
        mac = 0; mofs = 0; mdisp = 0; mcur = 0; mblink = 0; minc = 1; msh = 0;
    endtask

    // Reference effect of an accepted instruction byte, by value range.
    task automatic model_cmd(input logic [7:0] d);
        if (d >= 8'h80) mac = d[6:0];
        else if (d >= 8'h20) ;
        else if (d >= 8'h10) begin
            if (d[3]) mofs = wrap5(mofs, d[2]);
            else      mac  = {2'b00, wrap5(mac[4:0], d[2])};
        end else if (d >= 8'h08) begin
            mdisp = d[2]; mcur = d[1]; mblink = d[0];
        end else if (d >= 8'h04) begin
            minc = d[1]; msh = d[0];
        end else if (d >= 8'h02) begin
            mac = 0; mofs = 0;
        end else if (d == 8'h01) begin
            for (int i = 0; i < NCHAR; i++) mram[i] = 8'h20;
            mac = 0; mofs = 0;
        end
    endtask

    task automatic model_write(input logic [7:0] d);
        mram[mac[4:0]] = d;
        if (msh) mofs = wrap5(mofs, minc);
        mac = {2'b00, wrap5(mac[4:0], minc)};
    endtask

    // One bus cycle; returns at the negedge after the edge that takes it.
    task automatic cyc(input logic r_s, input logic r_w, input logic [7:0] d);
        @(negedge clk); rs = r_s; rw = r_w; din = d; en = 1'b1;
        @(negedge clk); en = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        repeat (LONG + 2) @(negedge clk);
    endtask

    task automatic wcmd(input logic [7:0] d);
        cyc(1'b0, 1'b0, d); model_cmd(d); idle();
    endtask

    task automatic wdat(input logic [7:0] d);
        cyc(1'b1, 1'b0, d); model_write(d); idle();
    endtask

    // Full comparison of visible state plus a status read of the counter.
    task automatic check_all(input string tag);
        chk({tag, " ram"}, 256'(ram_flat), 256'(model_flat()));
        chk({tag, " flags"}, 256'({disp_on, cursor_on, blink_on, entry_inc, entry_shift}),
            256'({mdisp, mcur, mblink, minc, msh}));
        chk({tag, " offset"}, 256'(shift_ofs), 256'(mofs));
        cyc(1'b0, 1'b1, 8'h00);
        chk({tag, " status"}, 256'(dout), 256'({1'b0, mac}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed_1cd0);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset defaults
        chk("R13 busy", 256'(busy), 256'(0));
        chk("R13 dout", 256'(dout), 256'(0));
        check_all("R13");

        // R2/R12: status read right after a write sees busy and the new counter
        cyc(1'b1, 1'b0, 8'h41); model_write(8'h41);
        cyc(1'b0, 1'b1, 8'h00);
        chk("R2 status while busy", 256'(dout), 256'(8'h81));
        idle();
        check_all("R10 first write");

        // R12 short busy length
        cyc(1'b0, 1'b0, 8'h0C); model_cmd(8'h0C);
        chk("R12 busy start", 256'(busy), 256'(1));
        repeat (SHORT - 1) @(negedge clk);
        chk("R12 short busy last", 256'(busy), 256'(1));
        @(negedge clk);
        chk("R12 short busy end", 256'(busy), 256'(0));
        idle();
        check_all("R6 display on");

        // R4/R12 long busy after home
        cyc(1'b0, 1'b0, 8'h03); model_cmd(8'h03);
        repeat (LONG - 1) @(negedge clk);
        chk("R12 long busy last", 256'(busy), 256'(1));
        @(negedge clk);
        chk("R12 long busy end", 256'(busy), 256'(0));
        idle();
        check_all("R4 home");

        // R12 second write while busy is dropped; R11 read while busy served
        wcmd(8'h80);
        cyc(1'b1, 1'b0, 8'h55); model_write(8'h55);
        cyc(1'b1, 1'b0, 8'h66);
        idle();
        check_all("R12 dropped write");
        wcmd(8'h80);
        cyc(1'b1, 1'b0, 8'h77); model_write(8'h77);
        cyc(1'b1, 1'b1, 8'h00);
        chk("R11 read while busy", 256'(dout), 256'(mram[mac[4:0]]));
        mac = {2'b00, wrap5(mac[4:0], minc)};
        idle();
        check_all("R11 read advance");

        // R5/R10 decrement wrap below zero
        wcmd(8'h04); wcmd(8'h80); wdat(8'h33);
        check_all("R10 decrement wrap");

        // R5/R10 scroll-on-write going up
        wcmd(8'h07); wdat(8'h34); wdat(8'h35);
        check_all("R10 scroll on write");

        // R9 counter load with high bits
        wcmd(8'hC5);
        check_all("R9 load 0x45");
        wdat(8'h5A);
        check_all("R10 write after high load");

        // R7 display and cursor shifts
        wcmd(8'h1C); wcmd(8'h18); wcmd(8'h18);
        check_all("R7 display shift");
        wcmd(8'h80); wcmd(8'h10);
        check_all("R7 cursor left wrap");
        wcmd(8'h14);
        check_all("R7 cursor right");

        // R8 no-effect instructions
        wcmd(8'h00); wcmd(8'h3F); wcmd(8'h20); wcmd(8'h7F); wcmd(8'h40);
        check_all("R8 no effect");

        // R3 clear
        wcmd(8'h01);
        check_all("R3 clear");

        // Random mix against the model (R1 R5 R6 R7 R9 R10 R11)
        for (int n = 0; n < 300; n++) begin
            int unsigned op;
            logic [7:0] b;
            op = $urandom % 4;
            b = 8'($urandom);
            case (op)
                0: wdat(b);
                1: wcmd(b);
                2: begin
                    cyc(1'b0, 1'b1, 8'h00);
                    chk("R2 random status", 256'(dout), 256'({1'b0, mac}));
                end
                default: begin
                    cyc(1'b1, 1'b1, 8'h00);
                    chk("R11 random read", 256'(dout), 256'(mram[mac[4:0]]));
                    mac = {2'b00, wrap5(mac[4:0], minc)};
                end
            endcase
            if (n % 25 == 0) check_all("R1 random mix");
        end
        check_all("R1 random end");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule